// File: doc/BRIEF.md
# CRC-Guarded Register Bank Target Engine

This block is the target-side transaction engine for a bank of 64 byte-wide registers. Every access to the bank is protected by an 8-bit checksum. The engine sits behind a byte-level serial bus front end that has already decoded bit timing. That front end supplies:

- start and stop strobes;
- a direction flag valid with the start strobe;
- a strobe for each received byte;
- a request strobe whenever it has shifted out the current transmit byte.

The engine checks the device address byte and captures the register byte. It keeps write data in a staging buffer until the checksum is proven. For reads it appends its own checksum after the data.

A write transaction carries, in order:

1. the device address byte;
2. the register byte;
3. one to four data bytes;
4. the checksum;
5. one filler byte.

A read first loads the register byte with a write-direction transaction that carries no data. A read-direction transaction then clocks out the data followed by the checksum. A wrong checksum or a truncated write leaves the bank untouched and raises a sticky flag.

Top module: `crcreg_engine`

## Requirements
- R1: The checksum is CRC-8 with polynomial 0x07, processed most significant bit first, with an initial value of 0x00 and no final inversion. It runs over the device address byte, then the register byte, then the data bytes. The device address byte is the 7-bit address shifted left by one, with bit 0 set to 0 for write and 1 for read.
- R2: In the register byte, bits [5:0] give the starting offset and bits [7:6] give the byte count minus one. So 00 selects 1 byte, 10 selects 3 bytes and 11 selects 4 bytes.
- R3: Write data bytes are committed to the bank only when the byte that follows the last data byte equals the computed checksum.
- R4: On a write checksum mismatch no register changes, and `crc_error` goes to 1 and stays at 1 until reset.
- R5: A stop or a new start that arrives after at least one write data byte but before the checksum byte discards the write. It also sets `length_error`, which stays at 1 until reset. A write-direction transaction that ends right after the register byte is not an error.
- R6: The filler byte after the checksum, and any further received bytes of that transaction, have no effect.
- R7: In a read-direction transaction, `tx_byte` presents the data bytes selected by the stored register byte one at a time, each advanced by `tx_req`. After the data comes the checksum computed over the read address byte (bit 0 = 1), the stored register byte and the data.
- R8: Once the checksum has been consumed, every further `tx_req` in that read yields 0xFF.
- R9: Within a burst, offsets increment by one and wrap from 63 to 0, for both reads and writes.
- R10: A transaction whose device address byte differs from the parameterized address and direction is ignored entirely. It writes nothing, flags nothing and leaves the stored register byte unchanged.
- R11: After reset all registers read 0x00, both flags are 0, `tx_byte` is 0xFF and the stored register byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_start | input | 1 | One-cycle strobe: (repeated) start seen |
| bus_stop | input | 1 | One-cycle strobe: stop seen |
| bus_rd | input | 1 | Direction of the transaction, sampled with `bus_start` (1 = read) |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | One-cycle strobe: current `tx_byte` was sent, advance |
| tx_byte | output | 8 | Byte to transmit next |
| crc_error | output | 1 | Sticky write checksum mismatch flag |
| length_error | output | 1 | Sticky truncated write flag |

## Verification
The bench writes a 4-byte burst starting at offset 62. A design that does not wrap would write past the end of the bank or drop bytes 0 and 1, and the read-back exposes this. A corrupted checksum must leave earlier contents in place. A design that commits bytes as they arrive, rather than from the staging buffer, would show the new data. A write cut off by a stop, and another cut off by a repeated start, must both raise the length flag without touching the bank. The bench also checks that an address-only phase does not raise the flag. The read checksum must cover the read-direction address byte. A design that reused the write address byte would return a different checksum. A transaction to another device must not disturb the stored register byte, so a later read must return data from the earlier offset.

// File: rtl/crcreg_pkg.sv
package crcreg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start
    ST_DEV,    // expecting the device address byte
    ST_REG,    // expecting the register byte (write direction)
    ST_WDATA,  // collecting write data into the staging buffer
    ST_WCRC,   // expecting the checksum byte
    ST_WTAIL,  // filler and any trailing bytes are dropped
    ST_RD,     // serving read data and checksum
    ST_SKIP    // transaction not for this target
  } eng_state_t;

  localparam logic [7:0] CRC_POLY = 8'h07;
  localparam logic [7:0] TX_IDLE  = 8'hFF;

endpackage

// File: rtl/crcreg_crc8.sv
// One byte step of an MSB-first CRC-8, unrolled over the eight bits.
module crcreg_crc8 #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic [7:0] crc_in,
  input  logic [7:0] data_in,
  output logic [7:0] crc_out
);

  logic [8:0][7:0] step;

  assign step[0] = crc_in ^ data_in;

  for (genvar b = 0; b < 8; b++) begin : g_bit
    assign step[b+1] = step[b][7] ? ({step[b][6:0], 1'b0} ^ POLY)
                                  : {step[b][6:0], 1'b0};
  end

  assign crc_out = step[8];

endmodule

// File: rtl/crcreg_stage.sv
// Holding buffer for write data until the checksum has been proven.
module crcreg_stage #(
  parameter int MAXB = 4,
  localparam int IDXW = (MAXB > 1) ? $clog2(MAXB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [IDXW-1:0]   load_idx,
  input  logic [7:0]        load_byte,
  output logic [MAXB*8-1:0] flat
);

  for (genvar s = 0; s < MAXB; s++) begin : g_slot
    logic       hit;
    logic [7:0] slot_q;

    assign hit = load_en && (load_idx == IDXW'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= 8'h00;
      end else if (hit) begin
        slot_q <= load_byte;
      end
    end

    assign flat[s*8 +: 8] = slot_q;
  end

endmodule

// File: rtl/crcreg_regfile.sv
// Byte register array with a wrapping burst write port and one read port.
// DEPTH must be a power of two so that offset arithmetic wraps naturally.
module crcreg_regfile #(
  parameter int DEPTH = 64,
  parameter int MAXB  = 4,
  localparam int OFFW = $clog2(DEPTH),
  localparam int CNTW = $clog2(MAXB + 1),
  localparam int IDXW = (MAXB > 1) ? $clog2(MAXB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFFW-1:0]   wr_base,
  input  logic [CNTW-1:0]   wr_cnt,
  input  logic [MAXB*8-1:0] wr_data,
  input  logic [OFFW-1:0]   rd_addr,
  output logic [7:0]        rd_data
);

  logic [DEPTH-1:0][7:0] cells;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [OFFW-1:0] rel;
    logic            hit;
    logic [7:0]      cell_q;

    assign rel = OFFW'(i) - wr_base;
    assign hit = wr_en && (rel < OFFW'(wr_cnt));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= 8'h00;
      end else if (hit) begin
        cell_q <= wr_data[rel[IDXW-1:0]*8 +: 8];
      end
    end

    assign cells[i] = cell_q;
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/crcreg_engine.sv
module crcreg_engine
  import crcreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h34,
  parameter int         DEPTH    = 64,
  parameter int         MAXB     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       bus_rd,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  output logic [7:0] tx_byte,
  output logic       crc_error,
  output logic       length_error
);

  localparam int OFFW = $clog2(DEPTH);
  localparam int CNTW = $clog2(MAXB + 1);
  localparam int IDXW = (MAXB > 1) ? $clog2(MAXB) : 1;
  localparam int LENW = 8 - OFFW;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  eng_state_t      state_q, state_d;
  logic            dir_q, dir_d;
  logic [7:0]      crc_q, crc_d;
  logic [7:0]      sreg_q, sreg_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [7:0]      tx_q, tx_d;
  logic            cerr_q, cerr_d;
  logic            lerr_q, lerr_d;

  logic            wr_en;
  logic            stage_en;
  logic [CNTW-1:0] wr_cnt;
  logic [CNTW-1:0] xfer_len;
  logic [OFFW-1:0] cur_off;
  logic [OFFW-1:0] rd_addr;
  logic [7:0]      rd_data;
  logic [MAXB*8-1:0] stage_flat;
  logic [7:0]      crc_rx_seed;
  logic [7:0]      crc_rx, crc_tx, crc_ra, crc_rb;
  logic [CNTW-1:0] cnt_inc;
  logic            mid_write;

  assign cur_off  = sreg_q[OFFW-1:0];
  assign xfer_len = CNTW'(sreg_q[7 -: LENW]) + CNTW'(1);
  assign wr_cnt   = xfer_len;
  assign cnt_inc  = cnt_q + CNTW'(1);
  assign rd_addr  = cur_off + OFFW'(cnt_q) + OFFW'(state_q == ST_RD);

  // a write is "in flight" once a data byte has been taken
  assign mid_write = ((state_q == ST_WDATA) && (cnt_q != '0)) || (state_q == ST_WCRC);

  // checksum datapaths
  assign crc_rx_seed = (state_q == ST_DEV) ? 8'h00 : crc_q;

  crcreg_crc8 #(.POLY(CRC_POLY)) u_crc_rx (
    .crc_in(crc_rx_seed), .data_in(rx_byte), .crc_out(crc_rx));

  crcreg_crc8 #(.POLY(CRC_POLY)) u_crc_tx (
    .crc_in(crc_q), .data_in(tx_q), .crc_out(crc_tx));

  crcreg_crc8 #(.POLY(CRC_POLY)) u_crc_ra (
    .crc_in(8'h00), .data_in({DEV_ADDR, 1'b1}), .crc_out(crc_ra));

  crcreg_crc8 #(.POLY(CRC_POLY)) u_crc_rb (
    .crc_in(crc_ra), .data_in(sreg_q), .crc_out(crc_rb));

  crcreg_stage #(.MAXB(MAXB)) u_stage (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_en   (stage_en),
    .load_idx  (cnt_q[IDXW-1:0]),
    .load_byte (rx_byte),
    .flat      (stage_flat)
  );

  crcreg_regfile #(.DEPTH(DEPTH), .MAXB(MAXB)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_base (cur_off),
    .wr_cnt  (wr_cnt),
    .wr_data (stage_flat),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    dir_d    = dir_q;
    crc_d    = crc_q;
    sreg_d   = sreg_q;
    cnt_d    = cnt_q;
    tx_d     = tx_q;
    cerr_d   = cerr_q;
    lerr_d   = lerr_q;
    wr_en    = 1'b0;
    stage_en = 1'b0;

    if (bus_start) begin
      if (mid_write) lerr_d = 1'b1;
      state_d = ST_DEV;
      dir_d   = bus_rd;
      cnt_d   = '0;
    end else if (bus_stop) begin
      if (mid_write) lerr_d = 1'b1;
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_DEV: begin
          if (rx_valid) begin
            if (rx_byte == {DEV_ADDR, dir_q}) begin
              if (dir_q) begin
                state_d = ST_RD;
                tx_d    = rd_data;
                crc_d   = crc_rb;
                cnt_d   = '0;
              end else begin
                state_d = ST_REG;
                crc_d   = crc_rx;
              end
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_REG: begin
          if (rx_valid) begin
            sreg_d  = rx_byte;
            crc_d   = crc_rx;
            cnt_d   = '0;
            state_d = ST_WDATA;
          end
        end
        ST_WDATA: begin
          if (rx_valid) begin
            stage_en = 1'b1;
            crc_d    = crc_rx;
            cnt_d    = cnt_inc;
            if (cnt_inc == xfer_len) state_d = ST_WCRC;
          end
        end
        ST_WCRC: begin
          if (rx_valid) begin
            if (rx_byte == crc_q) wr_en  = 1'b1;
            else                  cerr_d = 1'b1;
            state_d = ST_WTAIL;
          end
        end
        ST_RD: begin
          if (tx_req) begin
            if (cnt_q < xfer_len) begin
              crc_d = crc_tx;
              cnt_d = cnt_inc;
              if (cnt_inc < xfer_len) tx_d = rd_data;
              else                    tx_d = crc_tx;
            end else begin
              tx_d = TX_IDLE;
            end
          end
        end
        default: ;  // idle, filler tail and foreign transactions hold
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      crc_q   <= 8'h00;
      sreg_q  <= 8'h00;
      cnt_q   <= '0;
      tx_q    <= TX_IDLE;
      cerr_q  <= 1'b0;
      lerr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
      crc_q   <= crc_d;
      sreg_q  <= sreg_d;
      cnt_q   <= cnt_d;
      tx_q    <= tx_d;
      cerr_q  <= cerr_d;
      lerr_q  <= lerr_d;
    end
  end

  assign tx_byte      = tx_q;
  assign crc_error    = cerr_q;
  assign length_error = lerr_q;

endmodule

// File: rtl/crcreg_engine_chk.sv
module crcreg_engine_chk #(
  parameter int CNTW = 3,
  parameter int MAXB = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rx_valid,
  input logic            tx_req,
  input logic [7:0]      tx_byte,
  input logic            crc_error,
  input logic            length_error,
  input logic            wr_en,
  input logic [CNTW-1:0] wr_cnt
);

  AST_CRC_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    crc_error |=> crc_error);  // R4

  AST_LEN_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    length_error |=> length_error);  // R5

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_req && !rx_valid) |=> $stable(tx_byte));  // R7

  AST_COMMIT_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> rx_valid);  // R3

  AST_COMMIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_cnt >= CNTW'(1) && wr_cnt <= CNTW'(MAXB)));  // R2

  AST_COMMIT_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $stable(crc_error));  // R4

endmodule

bind crcreg_engine crcreg_engine_chk u_chk (.*);

// File: tb/crcreg_engine_tb.sv
module crcreg_engine_tb;

  localparam time CLK_P = 20ns;
  localparam logic [6:0] DEV = 7'h34;
  localparam logic [6:0] OTHER = 7'h35;

  logic       clk;
  logic       rst_n;
  logic       bus_start, bus_stop, bus_rd;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       tx_req;
  logic [7:0] tx_byte;
  logic       crc_error, length_error;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] exp_mem [64];
  bit exp_cerr = 0;
  bit exp_lerr = 0;

  crcreg_engine #(.DEV_ADDR(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .bus_rd(bus_rd), .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
    .tx_byte(tx_byte), .crc_error(crc_error), .length_error(length_error));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, expv);
    end
  endtask

  task automatic check_flags(input string req);
    check(req, {7'd0, crc_error}, {7'd0, exp_cerr});
    check(req, {7'd0, length_error}, {7'd0, exp_lerr});
  endtask

  task automatic pulse_start(input bit rd);
    @(negedge clk); bus_start = 1'b1; bus_rd = rd;
    @(negedge clk); bus_start = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0; rx_byte = 8'h00;
  endtask

  task automatic tx_pop();
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_start = 0; bus_stop = 0; bus_rd = 0;
    rx_valid = 0; rx_byte = 0; tx_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 64; i++) exp_mem[i] = 8'h00;
    exp_cerr = 0; exp_lerr = 0;
  endtask

  // write transaction: n data bytes, only 'cut' of them sent before ending;
  // abort_by_start ends a cut write with a repeated start instead of stop
  task automatic wr_txn(input logic [6:0] dev, input logic [7:0] regb,
                        input logic [31:0] dat, input bit corrupt, input int cut,
                        input int extra, input bit abort_by_start);
    int n;
    logic [7:0] c;
    n = int'(regb[7:6]) + 1;
    pulse_start(1'b0);
    send_byte({dev, 1'b0});
    c = ref_crc(8'h00, {dev, 1'b0});
    send_byte(regb);
    c = ref_crc(c, regb);
    for (int i = 0; i < n && i < cut; i++) begin
      send_byte(dat[i*8 +: 8]);
      c = ref_crc(c, dat[i*8 +: 8]);
    end
    if (cut >= n) begin
      send_byte(corrupt ? (c ^ 8'h5A) : c);
      send_byte(8'hA5);
      for (int i = 0; i < extra; i++) send_byte(8'h3C + 8'(i));
      if (dev == DEV) begin
        if (corrupt) exp_cerr = 1;
        else for (int i = 0; i < n; i++) exp_mem[(int'(regb[5:0]) + i) % 64] = dat[i*8 +: 8];
      end
    end else if (dev == DEV && cut > 0) begin
      exp_lerr = 1;
    end
    if (abort_by_start && cut < n) begin
      pulse_start(1'b0);
    end
    pulse_stop();
  endtask

  task automatic set_ptr(input logic [6:0] dev, input logic [7:0] regb);
    pulse_start(1'b0);
    send_byte({dev, 1'b0});
    send_byte(regb);
    pulse_stop();
  endtask

  task automatic rd_only(input logic [7:0] regb, input string req);
    int n;
    logic [7:0] c;
    logic [7:0] e;
    n = int'(regb[7:6]) + 1;
    pulse_start(1'b1);
    send_byte({DEV, 1'b1});
    c = ref_crc(ref_crc(8'h00, {DEV, 1'b1}), regb);
    for (int i = 0; i < n; i++) begin
      e = exp_mem[(int'(regb[5:0]) + i) % 64];
      check({req, " data"}, tx_byte, e);
      c = ref_crc(c, e);
      tx_pop();
    end
    check({"R7 crc ", req}, tx_byte, c);
    tx_pop();
    check("R8 tail", tx_byte, 8'hFF);
    tx_pop();
    check("R8 tail2", tx_byte, 8'hFF);
    pulse_stop();
  endtask

  task automatic rd_txn(input logic [7:0] regb, input string req);
    set_ptr(DEV, regb);
    rd_only(regb, req);
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 tx idle", tx_byte, 8'hFF);
    check_flags("R11 flags");
    // stored register byte resets to 0: read without setting it
    rd_only(8'h00, "R11 stored reg");
    rd_txn(8'hC0, "R11 zeros");
  endtask

  task automatic t_single();
    wr_txn(DEV, 8'h05, 32'h0000_00B7, 0, 99, 0, 0);
    rd_txn(8'h05, "R1 R3 single");
    rd_txn(8'h04, "R3 neighbour");
    check_flags("R3 flags");
  endtask

  task automatic t_lengths();
    wr_txn(DEV, 8'hD0, 32'h4433_2211, 0, 99, 0, 0);
    rd_txn(8'hD0, "R2 four");
    wr_txn(DEV, 8'hA0, 32'h00C3_C2C1, 0, 99, 0, 0);
    rd_txn(8'hE0, "R2 three then unchanged");
    wr_txn(DEV, 8'h48, 32'h0000_9988, 0, 99, 0, 0);
    rd_txn(8'hC8, "R2 two");
  endtask

  task automatic t_wrap();
    wr_txn(DEV, 8'hFE, 32'hD4D3_D2D1, 0, 99, 0, 0);
    rd_txn(8'hFE, "R9 wrap");
    rd_txn(8'hC0, "R9 low");
  endtask

  task automatic t_badcrc();
    wr_txn(DEV, 8'hD0, 32'hEEEE_EEEE, 1, 99, 0, 0);
    check_flags("R4 flag");
    rd_txn(8'hD0, "R4 no update");
    wr_txn(DEV, 8'h10, 32'h0000_0077, 0, 99, 0, 0);
    check_flags("R4 sticky");
    rd_txn(8'h10, "R4 later write");
  endtask

  task automatic t_abort();
    do_reset();
    set_ptr(DEV, 8'h20);
    check_flags("R5 address phase");
    wr_txn(DEV, 8'hE0, 32'h5555_5555, 0, 2, 0, 0);
    check_flags("R5 stop abort");
    rd_txn(8'hE0, "R5 no update");
    do_reset();
    wr_txn(DEV, 8'h60, 32'h0000_6666, 0, 1, 0, 1);
    check_flags("R5 start abort");
    rd_txn(8'h60, "R5 start no update");
  endtask

  task automatic t_tail();
    do_reset();
    wr_txn(DEV, 8'h4A, 32'h0000_1234, 0, 99, 3, 0);
    check_flags("R6 flags");
    rd_txn(8'hCA, "R6 tail ignored");
  endtask

  task automatic t_foreign();
    wr_txn(DEV, 8'h41, 32'h0000_ABCD, 0, 99, 0, 0);
    set_ptr(DEV, 8'h41);
    set_ptr(OTHER, 8'hF0);
    rd_only(8'h41, "R10 pointer kept");
    wr_txn(OTHER, 8'h41, 32'h0000_0F0F, 0, 99, 0, 0);
    wr_txn(OTHER, 8'h41, 32'h0000_0F0F, 0, 1, 0, 0);
    check_flags("R10 flags");
    rd_txn(8'h41, "R10 no write");
  endtask

  initial begin
    t_reset();
    t_single();
    t_lengths();
    t_wrap();
    t_badcrc();
    t_abort();
    t_tail();
    t_foreign();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule